// File: doc/BRIEF.md
# Debug Probe Reset Sequencer

This block lives on the probe side of a JTAG run-control link. It takes a target processor through a controlled reset so that a debugger can stop the core before it fetches its first instruction. The block pulls the active-low hard reset low first. It then pulses the active-low test reset while hard reset is still held. After test reset is released, it clocks a short TMS-high burst. The burst brings the TAP to its reset state on boards where the test-reset pin is not wired. Last, it opens a command window. During that window an external JTAG shifter can load halt commands while the core is still held in hard reset.

All delays are counted in ticks from an internal prescaler. The prescaler divides the system clock frequency down to the tick rate, and every interval is a parameter. A second mode pulses test reset and clocks the TMS burst without ever touching hard reset. This mode is used for hot-plug and for resynchronising with a target that was reset on its own. When no command-done handshake arrives while the window is open, hard reset is still released on time and a sticky status flag records the miss.

Top module: `debug_rst_seq`

## Requirements
- R1: After reset and while idle, hrst_no=1, trst_no=1, tck_o=0, tms_o=1, window_o=0, busy_o=0 and missed_o=0.
- R2: A start request sampled while idle with trst_only_i=0 pulls hrst_no low in the next cycle and sets busy_o.
- R3: In a full sequence, trst_no goes low exactly HR_TO_TR_TICKS ticks after hrst_no falls and stays low for TR_HOLD_TICKS ticks.
- R4: When trst_no is released, tck_o produces BURST_LEN cycles. Each cycle is TCK_HALF clocks low followed by TCK_HALF clocks high. tms_o stays 1 throughout.
- R5: window_o is 1 from the end of the TCK burst until hard reset is released. While it is 1, hrst_no=0 and trst_no=1.
- R6: hrst_no returns high exactly TR_TO_HR_TICKS ticks after trst_no returns high. At that point the sequence ends and busy_o falls.
- R7: missed_o is set when hard reset is released if cmd_done_i was never 1 while window_o was 1. This includes the last window cycle. missed_o is cleared by the next accepted start.
- R8: A start with trst_only_i=1 keeps hrst_no at 1 throughout. It pulls trst_no low for TR_HOLD_TICKS ticks, then clocks the TCK burst and returns to idle without opening a window. missed_o stays 0.
- R9: start_i and trst_only_i have no effect while busy_o=1. The running sequence continues unchanged.
- R10: One tick lasts CLK_HZ/TICK_HZ clock cycles. Each interval is measured from the cycle in which it begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a reset sequence |
| trst_only_i | input | 1 | With start_i: pulse test reset only |
| cmd_done_i | input | 1 | Halt commands have been shifted in |
| hrst_no | output | 1 | Hard reset to target, active low |
| trst_no | output | 1 | Test reset to target, active low |
| tck_o | output | 1 | Test clock during the TMS burst |
| tms_o | output | 1 | Test mode select, held high |
| window_o | output | 1 | Command window open |
| busy_o | output | 1 | Sequence in progress |
| missed_o | output | 1 | Last window closed without cmd_done_i |

## Verification
The bench builds the block with CLK_HZ=20 and TICK_HZ=2, which gives a 10-cycle tick. It sets the intervals to 3, 4 and 5 ticks, BURST_LEN=5 and TCK_HALF=2. With these values a whole full sequence lasts 120 cycles, so the bench can compare every output on every cycle against a timeline model. That makes the exact window edges reachable: a handshake on the first and on the last window cycle, and one a cycle too early. A start request issued in the last busy cycle is also reachable.

// File: rtl/dbg_rst_pkg.sv
// Shared types for the debug reset sequencer.
package dbg_rst_pkg;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_HR_LEAD,
        SEQ_TR_HOLD,
        SEQ_BURST,
        SEQ_WINDOW
    } seq_state_e;

endpackage

// File: rtl/dbg_interval_timer.sv
// Tick-based interval timer.
// A prescaler divides the clock by DIV to make ticks. After load_i, expire_o
// pulses for one cycle, exactly ticks_i*DIV cycles after the load edge.
// Assumes ticks_i >= 1 (a value of 0 is treated as 1).
module dbg_interval_timer #(
    parameter int DIV    = 50000,
    parameter int TICK_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [TICK_W-1:0] ticks_i,
    output logic              expire_o
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [TICK_W-1:0] cnt_q;
    logic [TICK_W-1:0] last_q;
    logic              run_q;
    logic              tick;

    assign tick     = run_q && (pre_q == PRE_LAST);
    assign expire_o = tick && (cnt_q == last_q);

    // Prescaler and tick counter; a load restarts both.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q  <= '0;
            cnt_q  <= '0;
            last_q <= '0;
            run_q  <= 1'b0;
        end else if (load_i) begin
            pre_q  <= '0;
            cnt_q  <= '0;
            last_q <= (ticks_i == '0) ? '0 : ticks_i - 1'b1;
            run_q  <= 1'b1;
        end else if (run_q) begin
            if (tick) begin
                pre_q <= '0;
                if (expire_o) run_q <= 1'b0;
                else          cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbg_tms_burst.sv
// TCK burst generator for the TMS-high TAP reset.
// After start_i it emits LEN clock periods on tck_o. Each period is HALF
// cycles low, then HALF cycles high. done_o pulses in the last cycle of the
// burst. Assumes start_i is not repeated while a burst is running.
module dbg_tms_burst #(
    parameter int LEN  = 5,
    parameter int HALF = 25
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic tck_o,
    output logic done_o
);
    localparam int PH_N   = 2 * LEN;
    localparam int PH_W   = (PH_N > 1) ? $clog2(PH_N) : 1;
    localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(PH_N - 1);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF - 1);

    logic              act_q;
    logic [PH_W-1:0]   ph_q;
    logic [HALF_W-1:0] half_q;
    logic              half_end;

    assign half_end = act_q && (half_q == HALF_LAST);
    assign done_o   = half_end && (ph_q == PH_LAST);
    assign tck_o    = act_q && ph_q[0];

    // Half-period and phase counters; odd phases are the high halves.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q  <= 1'b0;
            ph_q   <= '0;
            half_q <= '0;
        end else if (start_i) begin
            act_q  <= 1'b1;
            ph_q   <= '0;
            half_q <= '0;
        end else if (act_q) begin
            if (half_end) begin
                half_q <= '0;
                if (done_o) act_q <= 1'b0;
                else        ph_q  <= ph_q + 1'b1;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/debug_rst_seq.sv
// Debug probe reset sequencer (top).
// Sequence: hard reset low, then test reset pulsed, then a TMS-high TCK burst,
// then a command window, then hard reset released. In test-reset-only mode
// hard reset is never driven. Assumes BURST_LEN*2*TCK_HALF is shorter than
// TR_TO_HR_TICKS ticks; if it is not, hard reset is released on schedule
// regardless.
module debug_rst_seq #(
    parameter int CLK_HZ         = 50_000_000,
    parameter int TICK_HZ        = 1000,
    parameter int HR_TO_TR_TICKS = 100,
    parameter int TR_HOLD_TICKS  = 100,
    parameter int TR_TO_HR_TICKS = 100,
    parameter int BURST_LEN      = 5,
    parameter int TCK_HALF       = 25,
    parameter int TICK_W         = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic trst_only_i,
    input  logic cmd_done_i,
    output logic hrst_no,
    output logic trst_no,
    output logic tck_o,
    output logic tms_o,
    output logic window_o,
    output logic busy_o,
    output logic missed_o
);
    import dbg_rst_pkg::*;

    localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
    localparam logic [TICK_W-1:0] T_LEAD = TICK_W'(HR_TO_TR_TICKS);
    localparam logic [TICK_W-1:0] T_HOLD = TICK_W'(TR_HOLD_TICKS);
    localparam logic [TICK_W-1:0] T_WIN  = TICK_W'(TR_TO_HR_TICKS);

    seq_state_e        state_q, state_d;
    logic              mode_q;
    logic              seen_q;
    logic              missed_q;
    logic              tmr_load;
    logic [TICK_W-1:0] tmr_ticks;
    logic              tmr_expire;
    logic              burst_go;
    logic              burst_done;
    logic              accept;
    logic              hr_release;

    dbg_interval_timer #(.DIV(DIV), .TICK_W(TICK_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (tmr_load),
        .ticks_i (tmr_ticks),
        .expire_o(tmr_expire)
    );

    dbg_tms_burst #(.LEN(BURST_LEN), .HALF(TCK_HALF)) u_burst (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(burst_go),
        .tck_o  (tck_o),
        .done_o (burst_done)
    );

    assign accept     = (state_q == SEQ_IDLE) && start_i;
    assign hr_release = !mode_q && tmr_expire &&
                        ((state_q == SEQ_WINDOW) || (state_q == SEQ_BURST));

    // Next-state decode, timer loads and burst launch.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_ticks = '0;
        burst_go  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    tmr_load = 1'b1;
                    if (trst_only_i) begin
                        state_d   = SEQ_TR_HOLD;
                        tmr_ticks = T_HOLD;
                    end else begin
                        state_d   = SEQ_HR_LEAD;
                        tmr_ticks = T_LEAD;
                    end
                end
            end
            SEQ_HR_LEAD: begin
                if (tmr_expire) begin
                    state_d   = SEQ_TR_HOLD;
                    tmr_load  = 1'b1;
                    tmr_ticks = T_HOLD;
                end
            end
            SEQ_TR_HOLD: begin
                if (tmr_expire) begin
                    state_d  = SEQ_BURST;
                    burst_go = 1'b1;
                    if (!mode_q) begin
                        tmr_load  = 1'b1;
                        tmr_ticks = T_WIN;
                    end
                end
            end
            SEQ_BURST: begin
                if (hr_release)      state_d = SEQ_IDLE;
                else if (burst_done) state_d = mode_q ? SEQ_IDLE : SEQ_WINDOW;
            end
            SEQ_WINDOW: begin
                if (tmr_expire) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Phase register and the mode captured at an accepted start.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SEQ_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) mode_q <= trst_only_i;
        end
    end

    // Handshake latch and the sticky missed-window flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q   <= 1'b0;
            missed_q <= 1'b0;
        end else if (accept) begin
            seen_q   <= 1'b0;
            missed_q <= 1'b0;
        end else begin
            if ((state_q == SEQ_WINDOW) && cmd_done_i) seen_q <= 1'b1;
            if (hr_release) missed_q <= !(seen_q || ((state_q == SEQ_WINDOW) && cmd_done_i));
        end
    end

    assign hrst_no  = (state_q == SEQ_IDLE) || mode_q;
    assign trst_no  = (state_q != SEQ_TR_HOLD);
    assign tms_o    = 1'b1;
    assign window_o = (state_q == SEQ_WINDOW);
    assign busy_o   = (state_q != SEQ_IDLE);
    assign missed_o = missed_q;
endmodule

// File: rtl/debug_rst_seq_checker.sv
// Port-level protocol checks for debug_rst_seq, attached by bind.
// Assumes a synchronous active-low reset held for at least one clock.
module debug_rst_seq_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic hrst_no,
    input logic trst_no,
    input logic tck_o,
    input logic tms_o,
    input logic window_o,
    input logic busy_o,
    input logic missed_o
);
    AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (hrst_no && trst_no && !tck_o && tms_o && !window_o)); // R1
    AST_START_TAKES_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o); // R2
    AST_TRST_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trst_no |-> busy_o); // R3
    AST_TCK_TMS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tck_o |-> (tms_o && trst_no)); // R4
    AST_WINDOW_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        window_o |-> (!hrst_no && trst_no && !tck_o)); // R5
    AST_HRST_AFTER_TRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hrst_no) |-> ($past(trst_no) && !busy_o)); // R6
    AST_MISSED_ONLY_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(missed_o) |-> $rose(hrst_no)); // R7
endmodule

bind debug_rst_seq debug_rst_seq_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .hrst_no (hrst_no),
    .trst_no (trst_no),
    .tck_o   (tck_o),
    .tms_o   (tms_o),
    .window_o(window_o),
    .busy_o  (busy_o),
    .missed_o(missed_o)
);

// File: tb/debug_rst_seq_bench.sv
// Cycle-accurate timeline bench for debug_rst_seq with short intervals.
module debug_rst_seq_bench;
    localparam int DIV   = 10;
    localparam int A     = 3 * DIV;           // hard reset lead
    localparam int B     = A + 4 * DIV;       // test reset release, full mode
    localparam int BRST  = 5 * 2 * 2;         // burst length in cycles
    localparam int LFULL = B + 5 * DIV;       // hard reset release
    localparam int TB    = 4 * DIV;           // test reset release, trst-only
    localparam int LTR   = TB + BRST;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, tronly = 1'b0, cmd = 1'b0;
    logic hrst_n, trst_n, tck, tms, win, busy, missed;
    int   vecs = 0, errs = 0;
    bit   done_flag = 0;

    always #10 clk = ~clk;

    debug_rst_seq #(
        .CLK_HZ(20), .TICK_HZ(2), .HR_TO_TR_TICKS(3), .TR_HOLD_TICKS(4),
        .TR_TO_HR_TICKS(5), .BURST_LEN(5), .TCK_HALF(2), .TICK_W(8)
    ) u_debug_rst_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .trst_only_i(tronly),
        .cmd_done_i(cmd), .hrst_no(hrst_n), .trst_no(trst_n), .tck_o(tck),
        .tms_o(tms), .window_o(win), .busy_o(busy), .missed_o(missed)
    );

    task automatic chk(string req, string name, logic act, logic exp, int k);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s at k=%0d: got %b expected %b", req, name, k, act, exp);
        end
    endtask

    function automatic logic exp_tck(int k, int b0);
        if (k < b0 || k >= b0 + BRST) return 1'b0;
        return (((k - b0) / 2) % 2) == 1;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    // One sequence: cmd_k = cycle of the handshake pulse, xk = cycle of a
    // spurious start while busy (-1 for none).
    task automatic run_seq(bit tr, int cmd_k, int xk);
        int  len = tr ? LTR : LFULL;
        bit  hit = !tr && cmd_k >= B + BRST && cmd_k <= LFULL - 1;
        string rq;
        @(negedge clk);
        start = 1'b1; tronly = tr;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < len + 6; k++) begin
            rq = tr ? "R8" : "R3";
            if (tr) begin
                chk("R8", "hrst_n", hrst_n, 1'b1, k);
                chk("R8", "trst_n", trst_n, k >= TB, k);
                chk("R8/R4", "tck", tck, exp_tck(k, TB), k);
                chk("R8", "window", win, 1'b0, k);
                chk("R8", "missed", missed, 1'b0, k);
            end else begin
                chk("R2/R6/R10", "hrst_n", hrst_n, k >= LFULL, k);
                chk(rq, "trst_n", trst_n, !(k >= A && k < B), k);
                chk("R4", "tck", tck, exp_tck(k, B), k);
                chk("R5", "window", win, k >= B + BRST && k < LFULL, k);
                chk("R7", "missed", missed, (k >= LFULL) ? !hit : 1'b0, k);
            end
            chk("R4", "tms", tms, 1'b1, k);
            chk("R9", "busy", busy, k < len, k);
            cmd    = (k == cmd_k);
            start  = (k == xk);
            tronly = 1'($urandom % 2);
            @(negedge clk);
        end
        cmd = 1'b0; start = 1'b0; tronly = 1'b0;
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (4) @(negedge clk);
        // R1: idle state after reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "hrst_n", hrst_n, 1'b1, 0);
        chk("R1", "trst_n", trst_n, 1'b1, 0);
        chk("R1", "tck", tck, 1'b0, 0);
        chk("R1", "tms", tms, 1'b1, 0);
        chk("R1", "window", win, 1'b0, 0);
        chk("R1", "busy", busy, 1'b0, 0);
        chk("R1", "missed", missed, 1'b0, 0);
        // Directed window edges for R7
        run_seq(0, B + BRST, -1);       // first window cycle: hit
        run_seq(0, LFULL - 1, -1);      // last window cycle: hit
        run_seq(0, B + BRST - 1, -1);   // one cycle early: missed
        run_seq(1, 5, -1);              // R8 clears missed
        run_seq(0, -1, LFULL - 1);      // R9 start in last busy cycle
        run_seq(1, 20, LTR - 1);
        // Random mix
        for (int i = 0; i < 16; i++) begin
            bit tr = 1'($urandom % 3 == 0);
            int l  = tr ? LTR : LFULL;
            run_seq(tr, int'($urandom % (l + 2)) - 1, int'($urandom % l));
        end
        summary();
        done_flag = 1;
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule